// File: doc/BRIEF.md
# Temperature Sensor Conversion Controller

This block sits between a simple 32-bit register bus and an on-chip temperature sensing front end. Software turns on the sensor and its converter with two separate bits in a mode register. The block then counts out a fixed warm-up interval. Once that interval has passed and a start bit is set, it asks the front end for a new conversion at a fixed period and loads each returned 12-bit code into a result register.

The front end is outside this block. It is represented by a one-cycle request output and a done strobe that carries a 12-bit code. Two calibration words from fuses are passed through as read-only registers, masked down to a valid flag and a 12-bit value. The block does no temperature arithmetic. Averaging and conversion to degrees are left to software.

The warm-up and the conversion period are set in microseconds. They become cycle counts through the clock frequency parameter. With the default 100 MHz clock they are 6000 and 2000 cycles.

Top module: `temp_sense_ctrl`

## Requirements
- R1: After reset every register reads zero, the status running bit is 0 and `conv_req` is low.
- R2: The mode register at offset 0x00 holds a sensor-enable bit (bit 0) and a converter-enable bit (bit 1). Conversions can run only while both bits are 1. With just one of them set, the status never shows running and no request is issued.
- R3: Once both enable bits are 1, the block becomes ready exactly SETTLE_US × CLK_HZ / 1e6 cycles after the write that completed the pair. With a start request pending, status bit 0 is 0 in the cycle before that point and 1 from that point on.
- R4: The start bit is bit 0 at offset 0x04. A start written before warm-up ends is kept and acts when warm-up completes. A start written after warm-up shows as running in the very next cycle.
- R5: Status bit 0 at offset 0x10 reads 1 exactly while conversions are running. All other status bits read 0.
- R6: `conv_req` is a one-cycle pulse. It is issued in the first running cycle and then every PERIOD_US × CLK_HZ / 1e6 cycles while running continues.
- R7: A `conv_done` pulse seen while running loads `conv_code` into bits 11:0 of the result register at offset 0x0C. Bits 31:12 read 0.
- R8: The result register keeps its last value between conversions. A `conv_done` seen while not running leaves it unchanged.
- R9: Clearing the start bit stops requests and clears running in the next cycle, and warm-up is not repeated on a later start. Clearing either enable bit also stops conversions, and the full warm-up runs again once both enable bits are set again.
- R10: The calibration registers at offsets 0x18 and 0x1C return `fuse_word0` and `fuse_word1` masked to bit 31 (valid flag) and bits 11:0 (value). All other bits read 0, and writes to these offsets have no effect.
- R11: The mode register reads back its two bits and the start register reads back its bit. Offsets with no register behind them read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address during a read |
| fuse_word0 | input | 32 | First calibration fuse word |
| fuse_word1 | input | 32 | Second calibration fuse word |
| conv_req | output | 1 | One-cycle conversion request to the front end |
| conv_done | input | 1 | Front end finished a conversion |
| conv_code | input | 12 | Code delivered with `conv_done` |

## Verification
A warm-up counter that is off by even one count shows in the status bit and the first `conv_req` a cycle too early or too late, so both are sampled on each side of the expected boundary. A period counter that wraps wrongly shows as a gap between requests that differs from 2000 cycles, and the bench catches this at the second request. A ready flag that survives disabling would make running return sooner than a full warm-up after re-enabling, and the restart boundary is checked the same way. A result register that loads outside the running state shows up on the next read after a done strobe given while the block is stopped.

// File: rtl/temp_sense_ctrl.sv
module temp_sense_ctrl #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SETTLE_US = 60,
  parameter int PERIOD_US = 20,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       fuse_word0,
  input  logic [31:0]       fuse_word1,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [11:0]       conv_code
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int PERIOD_CYC = CYC_PER_US * PERIOD_US;
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(PERIOD_CYC + 1);

  localparam logic [ADDR_W-1:0] OFS_MODE  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_START = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_RES   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFS_CAL0  = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFS_CAL1  = ADDR_W'('h1C);

  logic [1:0]    mode_q;
  logic          start_q;
  logic [11:0]   result_q;
  logic [SW-1:0] settle_cnt;
  logic          ready_q;
  logic [PW-1:0] tick;

  wire wr      = bus_sel & bus_we;
  wire enabled = &mode_q;
  wire running = enabled & ready_q & start_q;

  assign conv_req = running & (tick == '0);

  wire unused_bits = ^{bus_wdata[31:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 2'b00;
      start_q <= 1'b0;
    end else if (wr) begin
      if (bus_addr == OFS_MODE)  mode_q  <= bus_wdata[1:0];
      if (bus_addr == OFS_START) start_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      ready_q    <= 1'b0;
    end else if (!enabled) begin
      settle_cnt <= '0;
      ready_q    <= 1'b0;
    end else if (!ready_q) begin
      if (settle_cnt == SW'(SETTLE_CYC - 1)) ready_q <= 1'b1;
      else settle_cnt <= settle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= '0;
    else if (!running) tick <= '0;
    else if (tick == PW'(PERIOD_CYC - 1)) tick <= '0;
    else tick <= tick + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else if (conv_done && running) result_q <= conv_code;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        OFS_MODE:  bus_rdata = {30'd0, mode_q};
        OFS_START: bus_rdata = {31'd0, start_q};
        OFS_RES:   bus_rdata = {20'd0, result_q};
        OFS_STAT:  bus_rdata = {31'd0, running};
        OFS_CAL0:  bus_rdata = {fuse_word0[31], 19'd0, fuse_word0[11:0]};
        OFS_CAL1:  bus_rdata = {fuse_word1[31], 19'd0, fuse_word1[11:0]};
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_run_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (mode_q == 2'b11));

  assert_settle_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> ($past(settle_cnt) == SW'(SETTLE_CYC - 1)));

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  assert_first_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> conv_req);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(result_q));

  assert_quiet_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_q |-> !conv_req);

endmodule

// File: tb/temp_sense_ctrl_bench.sv
module temp_sense_ctrl_bench;
  localparam int SETTLE = 6000;
  localparam int PERIOD = 2000;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [31:0] fuse_word0 = 32'hFF00_FABC;
  logic [31:0] fuse_word1 = 32'h1234_51F7;
  logic conv_req, conv_done = 0;
  logic [11:0] conv_code = 0;

  int total = 0, bad = 0;
  int cyc = 0;
  int last_req = -1;
  bit finished = 0;
  logic [11:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  temp_sense_ctrl u_temp_sense_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_word0(fuse_word0), .fuse_word1(fuse_word1),
    .conv_req(conv_req), .conv_done(conv_done), .conv_code(conv_code));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1 if (conv_req) seen++;
    end
    check(req, seen, 0);
  endtask

  // driver: answers one request and pushes the expected result
  task automatic convert(logic [11:0] code, bit spaced);
    logic [31:0] d;
    int guard = 0;
    #1;
    while (!conv_req && guard < 3 * PERIOD) begin
      @(negedge clk); #1; guard++;
    end
    check("R6 request seen", conv_req, 1);
    if (spaced) check("R6 request period", cyc - last_req, PERIOD);
    last_req = cyc;
    repeat (2) @(negedge clk);
    conv_done = 1; conv_code = code;
    exp_q.push_back(code);
    @(negedge clk);
    conv_done = 0;
    rd(8'h0C, d);
    check("R7 result load", d, {20'd0, exp_q.pop_front()});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, d); check("R1 mode", d, 0);
    rd(8'h04, d); check("R1 start", d, 0);
    rd(8'h0C, d); check("R1 result", d, 0);
    rd(8'h10, d); check("R1 status", d, 0);
    check("R1 conv_req", conv_req, 0);
    // R10 trim words
    rd(8'h18, d); check("R10 cal0", d, 32'h8000_0ABC);
    rd(8'h1C, d); check("R10 cal1", d, 32'h0000_01F7);
    wr(8'h18, 32'h0);
    rd(8'h18, d); check("R10 cal0 write ignored", d, 32'h8000_0ABC);
    rd(8'h08, d); check("R11 unmapped", d, 0);
    // R2 single enable, start pending
    wr(8'h00, 32'hFFFF_FFF1);
    wr(8'h04, 1);
    rd(8'h00, d); check("R11 mode readback", d, 1);
    rd(8'h04, d); check("R11 start readback", d, 1);
    quiet(SETTLE + 50, "R2 only sensor enable");
    rd(8'h10, d); check("R2 status idle", d, 0);
    wr(8'h00, 2);
    quiet(SETTLE + 50, "R2 only converter enable");
    // R3/R4 full enable with latched start
    wr(8'h00, 3);
    repeat (SETTLE - 2) @(negedge clk);
    rd(8'h10, d); check("R3 before settle", d, 0);
    rd(8'h10, d); check("R3 R4 R5 at settle", d, 1);
    check("R6 first request", conv_req, 1);
    convert(12'h3A5, 0);
    convert(12'hFFF, 1);
    convert(12'h001, 1);
    // R8 hold between conversions
    repeat (100) @(negedge clk);
    rd(8'h0C, d); check("R8 hold", d, 32'h001);
    // R9 stop via start bit
    wr(8'h04, 0);
    rd(8'h10, d); check("R9 start cleared", d, 0);
    @(negedge clk);
    conv_done = 1; conv_code = 12'h555;
    @(negedge clk);
    conv_done = 0;
    rd(8'h0C, d); check("R8 done ignored when stopped", d, 32'h001);
    quiet(PERIOD + 50, "R9 no requests after stop");
    // R4 restart without warm-up
    wr(8'h04, 1);
    #1 check("R4 immediate start", conv_req, 1);
    rd(8'h10, d); check("R4 running after start", d, 1);
    convert(12'h7E0, 0);
    // R9 disable and re-enable: full warm-up again
    wr(8'h00, 1);
    rd(8'h10, d); check("R9 disable stops", d, 0);
    quiet(50, "R9 quiet when disabled");
    wr(8'h00, 3);
    repeat (SETTLE - 2) @(negedge clk);
    rd(8'h10, d); check("R9 re-settle before", d, 0);
    rd(8'h10, d); check("R9 re-settle at", d, 1);
    convert(12'h246, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule